// File: doc/BRIEF.md
# Dual-Port Address-Collision Arbiter

This block watches the two ports of a true dual-port memory. The ports are independent of each other. When both ports are enabled on the same address, it picks one winner. It drives an active-low BUSY to the other port and suppresses that port's write strobe, so the winner's data reaches the array intact. Reads are never gated. A port that reads while its BUSY is asserted still receives data, but the value is not guaranteed.

A mode strap sets the role of the BUSY pins. In master mode the block arbitrates by itself and drives BUSY outward, with an output enable for each port's pad. In slave mode the pads are inputs and local arbitration is idle. An incoming BUSY then blocks the local write. Several memories can therefore be placed side by side for a wider word and all follow the one master's decision. The model is synchronous to a single clock: arrival order is judged against the previous cycle's enable and address of each port.

Top module: `dpa_collision_arb`

## Requirements
- R1: After reset, with both ports idle and the strap in master mode, neither BUSY output is asserted (both read 1) and neither write grant is set.
- R2: In master mode a BUSY output is asserted (0) only in a cycle where both ports are enabled and their addresses are bit-for-bit equal; ports enabled on different addresses both see BUSY at 1.
- R3: When a port becomes enabled on, or moves onto, the address the other port already holds enabled from the previous cycle, the newcomer receives BUSY in that same cycle and the port already present does not.
- R4: When both ports arrive on the same address in the same cycle, the left port wins and the right port receives BUSY.
- R5: The winner keeps the location for as long as the collision persists; if the loser drops its enable and comes back to the same address, it receives BUSY again.
- R6: BUSY is released in the same cycle the addresses stop matching or a port is disabled; a later collision is arbitrated afresh by arrival order.
- R7: In master mode both BUSY output enables are 1 and the incoming BUSY pins have no effect on the write grants.
- R8: In slave mode both BUSY output enables are 0, both BUSY outputs read 1, and a port's write grant is 0 whenever its incoming BUSY is 0, whatever the addresses are.
- R9: A write grant is 1 only for an enabled port with write selected (write select 1 = write) that is not blocked; in master mode the port holding BUSY gets no grant while the winner does.
- R10: At most one of the two BUSY outputs is asserted in any cycle.
- R11: The address width is a parameter from 12 to 14 bits, and every address bit, including the top one, takes part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| master_i | input | 1 | Mode strap: 1 = master (arbitrate, drive BUSY), 0 = slave |
| l_en_i | input | 1 | Left port enable |
| l_we_i | input | 1 | Left port write select (1 = write) |
| l_addr_i | input | AW | Left port address |
| r_en_i | input | 1 | Right port enable |
| r_we_i | input | 1 | Right port write select (1 = write) |
| r_addr_i | input | AW | Right port address |
| l_busy_n_i | input | 1 | Left BUSY pad input, used in slave mode (active low) |
| r_busy_n_i | input | 1 | Right BUSY pad input, used in slave mode (active low) |
| l_busy_n_o | output | 1 | Left BUSY pad output (active low) |
| r_busy_n_o | output | 1 | Right BUSY pad output (active low) |
| l_busy_oe_o | output | 1 | Left BUSY pad output enable |
| r_busy_oe_o | output | 1 | Right BUSY pad output enable |
| l_wr_grant_o | output | 1 | Left write allowed to reach the array |
| r_wr_grant_o | output | 1 | Right write allowed to reach the array |

## Verification
The bench builds the block with a 13-bit address, the middle of the allowed range. This lets it collide on the highest location, 0x1FFF. It also drives two addresses that differ only in the top bit, which shows that the comparator spans the full parameterised width. Default-width elaboration of the RTL covers the 12-bit end of the range.

// File: rtl/dpa_pkg.sv
`timescale 1ns/1ps
package dpa_pkg;
  // Which port currently holds a contested location
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;
endpackage

// File: rtl/dpa_addr_cmp.sv
`timescale 1ns/1ps
module dpa_addr_cmp #(
  parameter int unsigned AW = 12
) (
  input  logic          l_en_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          r_en_i,
  input  logic [AW-1:0] r_addr_i,
  output logic          match_o
);
  logic [AW-1:0] diff;

  always_comb begin
    diff    = l_addr_i ^ r_addr_i;
    match_o = l_en_i && r_en_i && (diff == '0);
  end
endmodule

// File: rtl/dpa_owner_fsm.sv
`timescale 1ns/1ps
module dpa_owner_fsm
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_i,
  input  logic          match_i,
  input  logic          l_en_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          r_en_i,
  input  logic [AW-1:0] r_addr_i,
  output owner_e        owner_o
);
  // previous-cycle view of each port, used to judge arrival order
  logic          l_en_q, r_en_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  owner_e        owner_q;

  logic          l_new, r_new;
  owner_e        owner_now;
  owner_e        owner_d;
  logic          hist_ce;

  always_comb begin
    l_new     = !(l_en_q && (l_addr_q == l_addr_i));
    r_new     = !(r_en_q && (r_addr_q == r_addr_i));
    owner_now = OWN_NONE;
    if (master_i && match_i) begin
      if (owner_q != OWN_NONE)      owner_now = owner_q;
      else if (l_new && !r_new)     owner_now = OWN_RIGHT;
      else                          owner_now = OWN_LEFT;
    end
    owner_d = owner_now;
    hist_ce = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      owner_q <= owner_d;
      if (hist_ce) begin
        l_en_q   <= l_en_i;
        r_en_q   <= r_en_i;
        l_addr_q <= l_addr_i;
        r_addr_q <= r_addr_i;
      end
    end
  end

  assign owner_o = owner_now;

  AST_OWNER_NEEDS_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_o != OWN_NONE) |-> (l_en_i && r_en_i && l_addr_i == r_addr_i)) else $error("owner without collision"); // R2
endmodule

// File: rtl/dpa_port_ctrl.sv
`timescale 1ns/1ps
module dpa_port_ctrl
  import dpa_pkg::*;
#(
  parameter owner_e LOSE_CODE = OWN_RIGHT
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   master_i,
  input  owner_e owner_i,
  input  logic   en_i,
  input  logic   we_i,
  input  logic   busy_n_i,
  output logic   busy_n_o,
  output logic   busy_oe_o,
  output logic   wr_grant_o
);
  logic blocked;
  logic lost;

  always_comb begin
    lost       = (owner_i == LOSE_CODE);
    blocked    = master_i ? lost : !busy_n_i;
    busy_n_o   = !(master_i && lost);
    busy_oe_o  = master_i;
    wr_grant_o = en_i && we_i && !blocked;
  end

  AST_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && !busy_n_o) |-> !wr_grant_o) else $error("loser write passed"); // R9
  AST_SLAVE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && !busy_n_i) |-> (!wr_grant_o && busy_n_o)) else $error("slave write not blocked"); // R8
endmodule

// File: rtl/dpa_collision_arb.sv
`timescale 1ns/1ps
module dpa_collision_arb
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_i,
  input  logic          l_en_i,
  input  logic          l_we_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          r_en_i,
  input  logic          r_we_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic          l_busy_n_i,
  input  logic          r_busy_n_i,
  output logic          l_busy_n_o,
  output logic          r_busy_n_o,
  output logic          l_busy_oe_o,
  output logic          r_busy_oe_o,
  output logic          l_wr_grant_o,
  output logic          r_wr_grant_o
);
  initial begin
    AST_AW_RANGE: assert (AW >= 12 && AW <= 14) else $error("AW out of range"); // R11
  end

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic   match;
  owner_e owner;

  dpa_addr_cmp #(.AW(AW)) i_cmp (
    .l_en_i   (l_en_i),
    .l_addr_i (l_addr_i),
    .r_en_i   (r_en_i),
    .r_addr_i (r_addr_i),
    .match_o  (match)
  );

  dpa_owner_fsm #(.AW(AW)) i_owner (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .master_i (master_i),
    .match_i  (match),
    .l_en_i   (l_en_i),
    .l_addr_i (l_addr_i),
    .r_en_i   (r_en_i),
    .r_addr_i (r_addr_i),
    .owner_o  (owner)
  );

  logic [NUM_PORTS-1:0] en_v, we_v, bin_v, bout_v, oe_v, gnt_v;

  always_comb begin
    en_v[PORT_L]  = l_en_i;   en_v[PORT_R]  = r_en_i;
    we_v[PORT_L]  = l_we_i;   we_v[PORT_R]  = r_we_i;
    bin_v[PORT_L] = l_busy_n_i; bin_v[PORT_R] = r_busy_n_i;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam owner_e LOSE = (p == PORT_L) ? OWN_RIGHT : OWN_LEFT;
    dpa_port_ctrl #(.LOSE_CODE(LOSE)) i_port (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .master_i   (master_i),
      .owner_i    (owner),
      .en_i       (en_v[p]),
      .we_i       (we_v[p]),
      .busy_n_i   (bin_v[p]),
      .busy_n_o   (bout_v[p]),
      .busy_oe_o  (oe_v[p]),
      .wr_grant_o (gnt_v[p])
    );
  end

  assign l_busy_n_o   = bout_v[PORT_L];
  assign r_busy_n_o   = bout_v[PORT_R];
  assign l_busy_oe_o  = oe_v[PORT_L];
  assign r_busy_oe_o  = oe_v[PORT_R];
  assign l_wr_grant_o = gnt_v[PORT_L];
  assign r_wr_grant_o = gnt_v[PORT_R];

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!l_busy_n_o || !r_busy_n_o) |-> (l_en_i && r_en_i && l_addr_i == r_addr_i)) else $error("busy without match"); // R2
  AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({~l_busy_n_o, ~r_busy_n_o}) <= 1) else $error("both ports busy"); // R10
  AST_RIGHT_STAYS_LOSER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (master_i && $past(master_i) && match && $past(match) && $past(!r_busy_n_o)) |-> !r_busy_n_o) else $error("right lost hold changed"); // R5
  AST_LEFT_STAYS_LOSER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (master_i && $past(master_i) && match && $past(match) && $past(!l_busy_n_o)) |-> !l_busy_n_o) else $error("left lost hold changed"); // R5
endmodule

// File: tb/test_dpa_collision_arb.sv
`timescale 1ns/1ps
module test_dpa_collision_arb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  typedef struct {
    logic  lb, rb, lg, rg, oe;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master, l_en, l_we, r_en, r_we, l_bi, r_bi;
  logic [AW-1:0] l_addr, r_addr;
  logic l_bo, r_bo, l_oe, r_oe, l_g, r_g;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dpa_collision_arb #(.AW(AW)) i_dpa_collision_arb (
    .clk(clk), .rst_n(rst_n), .master_i(master),
    .l_en_i(l_en), .l_we_i(l_we), .l_addr_i(l_addr),
    .r_en_i(r_en), .r_we_i(r_we), .r_addr_i(r_addr),
    .l_busy_n_i(l_bi), .r_busy_n_i(r_bi),
    .l_busy_n_o(l_bo), .r_busy_n_o(r_bo),
    .l_busy_oe_o(l_oe), .r_busy_oe_o(r_oe),
    .l_wr_grant_o(l_g), .r_wr_grant_o(r_g)
  );

  task automatic step(input logic m, input logic le, input logic lw, input logic [AW-1:0] la,
                      input logic re, input logic rw, input logic [AW-1:0] ra,
                      input logic lbi, input logic rbi,
                      input logic elb, input logic erb, input logic elg, input logic erg,
                      input string req);
    exp_t e;
    @(negedge clk);
    master = m; l_en = le; l_we = lw; l_addr = la;
    r_en = re; r_we = rw; r_addr = ra; l_bi = lbi; r_bi = rbi;
    e.lb = elb; e.rb = erb; e.lg = elg; e.rg = erg; e.oe = m; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: compares a quarter period after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if ({l_bo, r_bo, l_g, r_g, l_oe, r_oe} !== {e.lb, e.rb, e.lg, e.rg, e.oe, e.oe}) begin
          n_bad++;
          $display("FAIL %s: got busy_n=%b%b grant=%b%b oe=%b%b, expected busy_n=%b%b grant=%b%b oe=%b%b",
                   e.req, l_bo, r_bo, l_g, r_g, l_oe, r_oe, e.lb, e.rb, e.lg, e.rg, e.oe, e.oe);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    master = 1'b1; l_en = 0; l_we = 0; r_en = 0; r_we = 0;
    l_addr = '0; r_addr = '0; l_bi = 1; r_bi = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    //    m le lw la        re rw ra        lbi rbi  lb rb lg rg
    step(1, 0, 0, 13'd0,    0, 0, 13'd0,    1, 1,    1, 1, 0, 0, "R1 idle after reset");
    step(1, 1, 1, 13'd5,    0, 0, 13'd0,    1, 1,    1, 1, 1, 0, "R2 single port");
    step(1, 1, 1, 13'd5,    1, 1, 13'd5,    1, 1,    1, 0, 1, 0, "R3 right arrives later");
    step(1, 1, 1, 13'd5,    1, 1, 13'd5,    1, 1,    1, 0, 1, 0, "R3 collision held");
    step(1, 1, 1, 13'd5,    1, 1, 13'd6,    1, 1,    1, 1, 1, 1, "R6 release on mismatch");
    step(1, 1, 1, 13'd5,    1, 1, 13'd5,    1, 1,    1, 0, 1, 0, "R6 re-arbitrated");
    step(1, 1, 1, 13'd5,    0, 1, 13'd5,    1, 1,    1, 1, 1, 0, "R5 loser drops enable");
    step(1, 1, 1, 13'd5,    1, 1, 13'd5,    1, 1,    1, 0, 1, 0, "R5 loser retries");
    step(1, 1, 1, 13'd7,    1, 1, 13'd5,    1, 1,    1, 1, 1, 1, "R6 winner leaves");
    step(1, 1, 1, 13'd5,    1, 1, 13'd5,    1, 1,    0, 1, 0, 1, "R3 left arrives later");
    step(1, 0, 0, 13'd5,    0, 0, 13'd5,    1, 1,    1, 1, 0, 0, "R6 both disabled");
    step(1, 1, 1, 13'h1FFF, 1, 1, 13'h1FFF, 1, 1,    1, 0, 1, 0, "R4 R11 same-cycle tie at top");
    step(1, 1, 0, 13'h1FFF, 1, 0, 13'h1FFF, 1, 1,    1, 0, 0, 0, "R9 reads never granted");
    step(1, 0, 0, 13'd0,    0, 0, 13'd0,    1, 1,    1, 1, 0, 0, "R6 idle");
    step(1, 1, 1, 13'h1005, 1, 1, 13'h0005, 1, 1,    1, 1, 1, 1, "R11 top bit differs");
    step(1, 1, 1, 13'd8,    1, 1, 13'd9,    1, 1,    1, 1, 1, 1, "R2 distinct addresses");
    step(1, 0, 0, 13'd8,    1, 1, 13'd9,    1, 0,    1, 1, 0, 1, "R7 master ignores busy in");
    step(1, 0, 0, 13'd8,    0, 0, 13'd9,    1, 1,    1, 1, 0, 0, "R10 idle");
    step(0, 1, 1, 13'd3,    1, 1, 13'd3,    1, 1,    1, 1, 1, 1, "R8 slave no local arbitration");
    step(0, 1, 1, 13'd3,    1, 1, 13'd3,    0, 1,    1, 1, 0, 1, "R8 slave left blocked");
    step(0, 1, 1, 13'd3,    1, 1, 13'd4,    1, 0,    1, 1, 1, 0, "R8 slave right blocked");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule